// File: doc/BRIEF.md
# Packet buffer page allocator

This block manages an on-chip packet buffer that is cut into 256-byte pages. It keeps a map of free pages and a small table of live packets. Each packet owns one contiguous run of pages and is known by a short packet number. A host drives the block through an 8-bit command word. The top three bits of that word select an operation. For an allocation, the low bits give the page count minus one. The block returns an allocation result byte and an allocation-done event. It also keeps two packet-number queues of eight entries each: a transmit queue that the host fills, and a receive queue that the receive engine fills.

The receive engine asks for memory through its own request port. Each granted receive allocation is pushed straight onto the receive queue. The host then takes packets off the head of that queue, either keeping their pages or giving them back. Status is always visible on the outputs:
- a queue word with each queue head and its empty flag;
- a memory word with the free and total page counts;
- a busy bit in the command read-back.

While the busy bit is high after a release, new commands are dropped.

Top module: `pkt_page_mmu`

## Requirements
- R1: After reset the queue word reads 16'h8080 (both queues empty, heads 0), the memory word reads 16'h2020 (32 free of 32), the allocation result reads 8'h00 and the busy bit reads 0.
- R2: The operation is taken from command bits 7:5: 0 no-op, 1 allocate, 2 reset, 3 drop receive head, 4 drop and free receive head, 5 free the selected packet, 6 push the selected packet on the transmit queue, 7 empty the transmit queue. A no-op changes no output.
- R3: Allocate (code 1) reserves bits 4:0 plus one pages at the lowest page index where that many free pages sit in a row, and uses the lowest unused packet number (0 to 15). One cycle later the result byte is {1'b0, packet number} and alloc_done is high for one cycle.
- R4: An allocation fails if no run is long enough or no packet number is free. A failed allocation sets the result byte to 8'h80, leaves the page map unchanged and raises no alloc_done.
- R5: Free (code 5) returns all pages of the packet named on pkt_sel. A number that is not live, or is 16 or above, changes nothing.
- R6: Codes 4 and 5 hold cmd_rdata[0] high for exactly 4 cycles, starting the cycle after the command. Host commands and receive requests made while it is high are ignored.
- R7: Code 6 appends pkt_sel to the transmit queue, which shows its head on bits 6:0 and its empty flag on bit 7 of fifo_status. The push is ignored if the packet is not live or the queue already holds 8 entries.
- R8: A receive request is served only in a cycle with no command write and busy low. One cycle later rx_ack is high, with rx_fail and rx_pnum giving the result. A success also appends the packet to the receive queue, whose head is on fifo_status bits 14:8 and empty flag on bit 15. A request fails, with rx_pnum 0, when allocation fails or the receive queue holds 8 entries.
- R9: Code 3 removes the receive head and keeps its pages. Code 4 removes the head and frees its pages if it is still live. Both do nothing to the queue when it is empty.
- R10: Code 7 empties the transmit queue and leaves every allocation in place.
- R11: Code 2 returns the block to the reset state of R1.
- R12: The memory word gives the count of free pages in bits 15:8 and the total page count in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command word: operation in 7:5, page count minus one in 4:0 |
| pkt_sel | input | 7 | Packet number for free and transmit push |
| rx_req | input | 1 | Receive-side allocation request |
| rx_pages_m1 | input | 5 | Receive request page count minus one |
| cmd_rdata | output | 8 | Command read-back, busy on bit 0 |
| alloc_result | output | 8 | Last host allocation: failed flag on bit 7, packet number on 6:0 |
| alloc_done | output | 1 | One-cycle allocation-complete event |
| fifo_status | output | 16 | Receive empty, receive head, transmit empty, transmit head |
| mem_info | output | 16 | Free pages in 15:8, total pages in 7:0 |
| rx_ack | output | 1 | One-cycle receive request answer |
| rx_fail | output | 1 | Last receive request failed |
| rx_pnum | output | 7 | Packet number granted to the last receive request |

## Verification
The hardest case to reach is a fragmented page map. Here the free page count is large enough for a request, but no run of that length exists, so first-fit has to skip holes or fail. The bench builds this case by allocating packets of several sizes and then freeing some in the middle. Long random runs of mixed allocates and frees then keep the map broken up. The second hard case is packet-number exhaustion and receive-queue fullness. The bench drives these by a burst of single-page receive requests with no host drain in between. A cycle-level model in the bench is compared against every output on every clock.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int PNUM_W = 7;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RESET   = 3'd2,
        OP_RX_DROP = 3'd3,
        OP_RX_FREE = 3'd4,
        OP_FREE    = 3'd5,
        OP_TX_PUSH = 3'd6,
        OP_TX_CLR  = 3'd7
    } op_e;

    typedef struct packed {
        logic              empty;
        logic [PNUM_W-1:0] head;
    } qstat_t;

endpackage

// File: rtl/page_finder.sv
module page_finder #(
    parameter int NUM_PAGES = 32,
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int NEED_W = PG_W + 1
) (
    input  logic [NUM_PAGES-1:0] free_map,
    input  logic [NEED_W-1:0]    need,
    output logic                 found,
    output logic [PG_W-1:0]      start
);

    logic ok;

    always_comb begin
        found = 1'b0;
        start = '0;
        ok    = 1'b0;
        for (int s = NUM_PAGES - 1; s >= 0; s--) begin
            ok = (s + int'(need)) <= NUM_PAGES;
            for (int j = 0; j < NUM_PAGES; j++) begin
                if (j >= s && j < s + int'(need) && !free_map[j]) ok = 1'b0;
            end
            if (ok) begin
                found = 1'b1;
                start = PG_W'(s);
            end
        end
    end

endmodule

// File: rtl/pkt_queue.sv
module pkt_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 7,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= push_data;
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R7: the caller must never push into a full queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        !(push && full));

    // R9: the caller must never pop an empty queue
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));

endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
    import mmu_pkg::*;
#(
    parameter int NUM_PAGES   = 32,
    parameter int NUM_SLOTS   = 16,
    parameter int QDEPTH      = 8,
    parameter int BUSY_CYCLES = 4,
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int NEED_W = PG_W + 1,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_wdata,
    input  logic [PNUM_W-1:0] pkt_sel,
    input  logic              rx_req,
    input  logic [PG_W-1:0]   rx_pages_m1,
    output logic [7:0]        cmd_rdata,
    output logic [7:0]        alloc_result,
    output logic              alloc_done,
    output logic [15:0]       fifo_status,
    output logic [15:0]       mem_info,
    output logic              rx_ack,
    output logic              rx_fail,
    output logic [PNUM_W-1:0] rx_pnum
);

    logic [NUM_PAGES-1:0] free_map;
    logic [NUM_SLOTS-1:0] slot_valid;
    logic [PG_W-1:0]      slot_start [NUM_SLOTS];
    logic [NEED_W-1:0]    slot_cnt   [NUM_SLOTS];
    logic [BUSY_W-1:0]    busy_cnt;
    logic                 busy;

    op_e                  op;
    logic                 host_go, rx_go, rst_all;
    logic [NEED_W-1:0]    need;
    logic                 fit_found;
    logic [PG_W-1:0]      fit_start;
    logic                 slot_ok;
    logic [SLOT_W-1:0]    slot_idx;
    logic                 alloc_ok;
    logic [SLOT_W-1:0]    sel_idx, rxh_idx;
    logic                 sel_ok, rxh_ok;

    logic                 txq_push, txq_clear, txq_empty, txq_full;
    logic                 rxq_push, rxq_pop, rxq_empty, rxq_full;
    logic [PNUM_W-1:0]    txq_head, rxq_head;
    qstat_t               tx_st, rx_st;

    function automatic logic [NUM_PAGES-1:0] run_mask(input logic [PG_W-1:0] st,
                                                      input logic [NEED_W-1:0] n);
        logic [NUM_PAGES-1:0] m;
        for (int k = 0; k < NUM_PAGES; k++)
            m[k] = (k >= int'(st)) && (k < int'(st) + int'(n));
        return m;
    endfunction

    assign busy    = (busy_cnt != '0);
    assign op      = op_e'(cmd_wdata[7:5]);
    assign host_go = cmd_we && !busy;
    assign rx_go   = rx_req && !busy && !cmd_we;
    assign rst_all = host_go && (op == OP_RESET);
    assign need    = host_go ? NEED_W'(cmd_wdata[PG_W-1:0]) + NEED_W'(1)
                             : NEED_W'(rx_pages_m1) + NEED_W'(1);

    page_finder #(.NUM_PAGES(NUM_PAGES)) u_finder (
        .free_map (free_map),
        .need     (need),
        .found    (fit_found),
        .start    (fit_start)
    );

    always_comb begin
        slot_ok  = 1'b0;
        slot_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!slot_valid[i]) begin
                slot_ok  = 1'b1;
                slot_idx = SLOT_W'(i);
            end
        end
    end

    assign alloc_ok = fit_found && slot_ok;
    assign sel_idx  = pkt_sel[SLOT_W-1:0];
    assign sel_ok   = (int'(pkt_sel) < NUM_SLOTS) && slot_valid[sel_idx];
    assign rxh_idx  = rxq_head[SLOT_W-1:0];
    assign rxh_ok   = !rxq_empty && slot_valid[rxh_idx];

    assign txq_push  = host_go && (op == OP_TX_PUSH) && sel_ok && !txq_full;
    assign txq_clear = rst_all || (host_go && (op == OP_TX_CLR));
    assign rxq_push  = rx_go && alloc_ok && !rxq_full;
    assign rxq_pop   = host_go && ((op == OP_RX_DROP) || (op == OP_RX_FREE)) && !rxq_empty;

    pkt_queue #(.DEPTH(QDEPTH), .W(PNUM_W)) u_txq (
        .clk(clk), .rst(rst), .clear(txq_clear),
        .push(txq_push), .push_data(pkt_sel), .pop(1'b0),
        .head(txq_head), .empty(txq_empty), .full(txq_full)
    );

    pkt_queue #(.DEPTH(QDEPTH), .W(PNUM_W)) u_rxq (
        .clk(clk), .rst(rst), .clear(rst_all),
        .push(rxq_push), .push_data(PNUM_W'(slot_idx)), .pop(rxq_pop),
        .head(rxq_head), .empty(rxq_empty), .full(rxq_full)
    );

    always_ff @(posedge clk) begin
        if (rst || rst_all) begin
            free_map     <= '1;
            slot_valid   <= '0;
            alloc_result <= '0;
            alloc_done   <= 1'b0;
            rx_ack       <= 1'b0;
            rx_fail      <= 1'b0;
            rx_pnum      <= '0;
            busy_cnt     <= '0;
        end else begin
            alloc_done <= 1'b0;
            rx_ack     <= 1'b0;
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (host_go) begin
                case (op)
                    OP_ALLOC: begin
                        if (alloc_ok) begin
                            free_map             <= free_map & ~run_mask(fit_start, need);
                            slot_valid[slot_idx] <= 1'b1;
                            slot_start[slot_idx] <= fit_start;
                            slot_cnt[slot_idx]   <= need;
                            alloc_result         <= {1'b0, PNUM_W'(slot_idx)};
                            alloc_done           <= 1'b1;
                        end else begin
                            alloc_result <= 8'h80;
                        end
                    end
                    OP_FREE: begin
                        busy_cnt <= BUSY_W'(BUSY_CYCLES);
                        if (sel_ok) begin
                            free_map            <= free_map | run_mask(slot_start[sel_idx], slot_cnt[sel_idx]);
                            slot_valid[sel_idx] <= 1'b0;
                        end
                    end
                    OP_RX_FREE: begin
                        busy_cnt <= BUSY_W'(BUSY_CYCLES);
                        if (rxh_ok) begin
                            free_map            <= free_map | run_mask(slot_start[rxh_idx], slot_cnt[rxh_idx]);
                            slot_valid[rxh_idx] <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end else if (rx_go) begin
                rx_ack <= 1'b1;
                if (alloc_ok && !rxq_full) begin
                    free_map             <= free_map & ~run_mask(fit_start, need);
                    slot_valid[slot_idx] <= 1'b1;
                    slot_start[slot_idx] <= fit_start;
                    slot_cnt[slot_idx]   <= need;
                    rx_fail              <= 1'b0;
                    rx_pnum              <= PNUM_W'(slot_idx);
                end else begin
                    rx_fail <= 1'b1;
                    rx_pnum <= '0;
                end
            end
        end
    end

    assign tx_st       = '{empty: txq_empty, head: txq_head};
    assign rx_st       = '{empty: rxq_empty, head: rxq_head};
    assign fifo_status = {rx_st, tx_st};
    assign mem_info    = {8'($countones(free_map)), 8'(NUM_PAGES)};
    assign cmd_rdata   = {7'b0, busy};

    // R4: a failed host allocation leaves the page map as it was
    assert_fail_keeps_map_R4: assert property (@(posedge clk) disable iff (rst)
        (host_go && op == OP_ALLOC && !fit_found) |=> $stable(free_map));

    // R3: the done event only accompanies a successful result
    assert_done_means_ok_R3: assert property (@(posedge clk) disable iff (rst)
        alloc_done |-> !alloc_result[7]);

    // R6: a command written while busy changes neither map, queues nor result
    assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_we) |=> ($stable(free_map) && $stable(fifo_status) && $stable(alloc_result)));

    // R6: no allocation can complete in a busy window
    assert_busy_blocks_alloc_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !alloc_done);

    // R8: a granted receive request leaves the receive queue non-empty
    assert_rx_grant_queued_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_ack && !rx_fail) |-> !fifo_status[15]);

    // R12: free pages never exceed the total
    assert_free_bound_R12: assert property (@(posedge clk) disable iff (rst)
        mem_info[15:8] <= mem_info[7:0]);

endmodule

// File: tb/sim_pkt_page_mmu.sv
module sim_pkt_page_mmu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [7:0] wd = '0;
    logic [6:0] sel = '0;
    logic       rreq = 1'b0;
    logic [4:0] rpg = '0;
    logic [7:0] cmd_rdata, alloc_result;
    logic       alloc_done, rx_ack, rx_fail;
    logic [15:0] fifo_status, mem_info;
    logic [6:0] rx_pnum;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pkt_page_mmu u0 (
        .clk(clk), .rst(rst), .cmd_we(we), .cmd_wdata(wd), .pkt_sel(sel),
        .rx_req(rreq), .rx_pages_m1(rpg), .cmd_rdata(cmd_rdata),
        .alloc_result(alloc_result), .alloc_done(alloc_done),
        .fifo_status(fifo_status), .mem_info(mem_info),
        .rx_ack(rx_ack), .rx_fail(rx_fail), .rx_pnum(rx_pnum)
    );

    // behavioural reference
    bit m_free [32];
    bit m_val  [16];
    int m_st   [16];
    int m_cn   [16];
    int txq [$];
    int rxq [$];
    int m_busy;
    int e_ares;
    bit e_done, e_rxack, e_rxfail;
    int e_rxp;

    task automatic reset_model();
        for (int i = 0; i < 32; i++) m_free[i] = 1;
        for (int i = 0; i < 16; i++) m_val[i] = 0;
        txq.delete();
        rxq.delete();
        m_busy = 0; e_ares = 0; e_done = 0; e_rxack = 0; e_rxfail = 0; e_rxp = 0;
    endtask

    function automatic int find_run(int need);
        for (int s = 0; s + need <= 32; s++) begin
            bit ok = 1;
            for (int k = 0; k < need; k++) if (!m_free[s+k]) ok = 0;
            if (ok) return s;
        end
        return -1;
    endfunction

    function automatic int find_slot();
        for (int i = 0; i < 16; i++) if (!m_val[i]) return i;
        return -1;
    endfunction

    task automatic m_take(int sl, int s, int need);
        for (int k = 0; k < need; k++) m_free[s+k] = 0;
        m_val[sl] = 1; m_st[sl] = s; m_cn[sl] = need;
    endtask

    task automatic m_release(int i);
        for (int k = 0; k < m_cn[i]; k++) m_free[m_st[i]+k] = 1;
        m_val[i] = 0;
    endtask

    task automatic model_step();
        int need, s, sl, h;
        bit b;
        if (rst) begin reset_model(); return; end
        e_done = 0; e_rxack = 0;
        b = (m_busy > 0);
        if (m_busy > 0) m_busy--;
        if (we && !b) begin
            case (int'(wd[7:5]))
                1: begin
                    need = int'(wd[4:0]) + 1; s = find_run(need); sl = find_slot();
                    if (s >= 0 && sl >= 0) begin m_take(sl, s, need); e_ares = sl; e_done = 1; end
                    else e_ares = 8'h80;
                end
                2: reset_model();
                3: if (rxq.size() > 0) void'(rxq.pop_front());
                4: begin
                    m_busy = 4;
                    if (rxq.size() > 0) begin h = rxq.pop_front(); if (m_val[h]) m_release(h); end
                end
                5: begin m_busy = 4; if (sel < 16 && m_val[sel]) m_release(int'(sel)); end
                6: if (sel < 16 && m_val[sel] && txq.size() < 8) txq.push_back(int'(sel));
                7: txq.delete();
                default: ;
            endcase
        end else if (rreq && !b && !we) begin
            e_rxack = 1; need = int'(rpg) + 1; s = find_run(need); sl = find_slot();
            if (s >= 0 && sl >= 0 && rxq.size() < 8) begin
                m_take(sl, s, need); rxq.push_back(sl); e_rxfail = 0; e_rxp = sl;
            end else begin e_rxfail = 1; e_rxp = 0; end
        end
    endtask

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int nf = 0;
        int ef;
        for (int i = 0; i < 32; i++) nf += m_free[i];
        ef = ((rxq.size() == 0) << 15) | ((rxq.size() == 0 ? 0 : rxq[0]) << 8) |
             ((txq.size() == 0) << 7) | (txq.size() == 0 ? 0 : txq[0]);
        chk("R6",  int'(cmd_rdata), (m_busy > 0) ? 1 : 0, "busy");
        chk("R3",  int'(alloc_result), e_ares, "alloc_result");
        chk("R3",  int'(alloc_done), int'(e_done), "alloc_done");
        chk("R7",  int'(fifo_status), ef, "fifo_status");
        chk("R12", int'(mem_info), (nf << 8) | 32, "mem_info");
        chk("R8",  int'(rx_ack), int'(e_rxack), "rx_ack");
        chk("R8",  int'(rx_fail), int'(e_rxfail), "rx_fail");
        chk("R8",  int'(rx_pnum), e_rxp, "rx_pnum");
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic issue(logic [7:0] c, logic [6:0] p);
        we = 1'b1; wd = c; sel = p;
        cyc();
        we = 1'b0;
    endtask

    task automatic rx_ask(logic [4:0] p);
        rreq = 1'b1; rpg = p;
        cyc();
        rreq = 1'b0;
    endtask

    task automatic wait_idle();
        while (cmd_rdata[0]) cyc();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        reset_model();
        @(negedge clk);
        rst = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        chk("R1", int'(fifo_status), 16'h8080, "fifo after reset");
        chk("R1", int'(mem_info), 16'h2020, "mem after reset");
        chk("R1", int'(alloc_result), 0, "result after reset");
        chk("R1", int'(cmd_rdata), 0, "busy after reset");

        issue(8'h1F, 0);
        chk("R2", int'(mem_info), 16'h2020, "no-op with low bits set");

        issue(8'h21, 0);
        chk("R3", int'(alloc_result), 8'h00, "first allocate");
        chk("R3", int'(mem_info), 16'h1E20, "two pages taken");
        issue(8'h22, 0);
        issue(8'h3F, 0);
        chk("R4", int'(alloc_result), 8'h80, "oversize allocate");
        chk("R4", int'(mem_info), 16'h1B20, "map kept on failure");

        issue(8'hA0, 0);
        chk("R5", int'(mem_info), 16'h1D20, "free packet 0");
        issue(8'h20, 0);
        chk("R6", int'(mem_info), 16'h1D20, "allocate ignored while busy");
        chk("R6", int'(alloc_result), 8'h80, "result kept while busy");
        wait_idle();
        issue(8'hA9, 9);
        chk("R5", int'(mem_info), 16'h1D20, "free of dead packet");
        wait_idle();

        issue(8'h20, 0);
        chk("R3", int'(alloc_result), 8'h00, "first fit reuses page 0");
        issue(8'h21, 0);
        chk("R3", int'(alloc_result), 8'h02, "two pages skip used run");

        issue(8'hC0, 1); issue(8'hC0, 0); issue(8'hC0, 2); issue(8'hC0, 9);
        chk("R7", int'(fifo_status), 16'h8001, "transmit head");
        for (int i = 0; i < 7; i++) issue(8'hC0, 0);
        issue(8'hE0, 0);
        chk("R10", int'(fifo_status[7:0]), 8'h80, "transmit emptied");
        chk("R10", int'(mem_info), 16'h1A20, "allocations kept");

        for (int i = 0; i < 9; i++) rx_ask(5'd0);
        chk("R8", int'(rx_fail), 1, "receive queue full");
        chk("R8", int'(fifo_status[15:8]), 8'h03, "receive head");
        issue(8'h60, 0);
        chk("R9", int'(fifo_status[15:8]), 8'h04, "drop receive head");
        chk("R9", int'(mem_info), 16'h1220, "drop keeps pages");
        issue(8'h80, 0);
        chk("R9", int'(fifo_status[15:8]), 8'h05, "free receive head");
        chk("R9", int'(mem_info), 16'h1320, "freed one page");
        wait_idle();

        issue(8'h40, 0);
        chk("R11", int'(fifo_status), 16'h8080, "fifo after reset command");
        chk("R11", int'(mem_info), 16'h2020, "mem after reset command");
        chk("R11", int'(alloc_result), 0, "result after reset command");

        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            we = 1'b0; rreq = 1'b0;
            if (r < 45) begin
                int c = $urandom_range(0, 99);
                logic [2:0] code;
                if (c < 35) code = 3'd1;
                else if (c < 55) code = 3'd5;
                else if (c < 70) code = 3'd6;
                else if (c < 78) code = 3'd3;
                else if (c < 88) code = 3'd4;
                else if (c < 94) code = 3'd7;
                else if (c < 98) code = 3'd0;
                else code = 3'd2;
                we = 1'b1;
                wd = {code, 5'($urandom_range(0, ($urandom_range(0, 9) == 0) ? 31 : 5))};
                sel = 7'($urandom_range(0, 17));
            end
            if ($urandom_range(0, 99) < 35) begin
                rreq = 1'b1;
                rpg = 5'($urandom_range(0, 3));
            end
            cyc();
        end
        we = 1'b0; rreq = 1'b0;
        cyc();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule